// File: doc/BRIEF.md
# IF Rail Splitter with Half-Rate Even-Tap Shaping Filter

This block turns a stream of real-valued intermediate-frequency samples into baseband in-phase and quadrature rails without any mixer or oscillator. The input is taken at four samples per symbol, with the carrier at one quarter of the sample rate. At that ratio the two carriers, sampled, reduce to the sequences +1, 0, -1, 0 and 0, +1, 0, -1. Steering alternate samples to two rails, and negating the second half of every group of four, therefore performs the whole demodulation.

Each rail then runs at half the input rate through a pipelined 16-tap shaping filter. The filter takes the even-indexed taps of a 32-tap root-raised-cosine prototype. Its sum is rounded, scaled down and clipped to the output width, so the rails leave the block at two samples per symbol, both carried by one valid strobe.

A rail-swap input exchanges the two rails, which lets a later stage settle which rail is in-phase. A synchronous reset restarts the sample phase so that the inversion lines up with the carrier.

Top module: `if_rail_demod`

## Requirements
- R1: While `rst_n` is low on a clock edge, `out_vld`, `i_out` and `q_out` are zero after that edge. The sample phase and both filter histories are cleared, so the first accepted sample after reset counts as sample number 0.
- R2: Accepted samples are numbered from 0 since reset. With `swap_iq` low, even-numbered samples feed the I rail and odd-numbered samples feed the Q rail.
- R3: A sample whose number modulo 4 is 2 or 3 is negated before it enters a rail, and -512 negates to +511. Samples numbered 0 or 1 modulo 4 enter their rail unchanged.
- R4: `swap_iq` is sampled together with the odd-numbered sample of each pair. When it is high, that pair's even sample goes to the Q rail and its odd sample to the I rail.
- R5: For each rail, the filter sum is acc[n] = sum over k=0..15 of c[k]*r[n-k], where r[n] is the newest rail value. The taps c[0..15] are 7, -7, -12, 33, 8, -93, 27, 390, 511, 203, -77, -48, 38, 9, -16, 4.
- R6: Each output equals floor((acc + 512) / 1024), clipped to the range -512..511. This is a right shift by `NORM_SHIFT` = 10 that rounds halves upward.
- R7: Each completed pair yields exactly one single-cycle `out_vld` pulse carrying both rails. The pulse comes 7 clock edges after the edge that accepts the pair's odd sample, and `out_vld` is never high otherwise.
- R8: A cycle with `samp_vld` low is ignored: its sample value has no effect and the sample numbering does not advance. Between pulses `i_out` and `q_out` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| samp_vld | input | 1 | Input sample qualifier |
| samp | input | 10 | Signed IF sample |
| swap_iq | input | 1 | Exchange I and Q rails for the current pair |
| i_out | output | 10 | Filtered, normalized I rail sample |
| q_out | output | 10 | Filtered, normalized Q rail sample |
| out_vld | output | 1 | One-cycle strobe for i_out and q_out |

## Verification
Each rail result falls due exactly seven clock edges after the edge that accepts the odd sample of its pair. The bench records the expected pair against that cycle number at the moment it drives the sample. It then compares on the falling edge of every cycle in which either a result is due or the strobe is high, so an early, late or extra pulse counts as a mismatch. The reset checks are taken two cycles into reset, and any result still pending is withdrawn when reset is applied.

// File: rtl/if_rail_pkg.sv
package if_rail_pkg;
  localparam int COEF_W   = 10;
  localparam int MAX_TAPS = 16;

  // Even-indexed taps of the shaping prototype, newest sample first.
  function automatic int rrc_even_tap(input int k);
    case (k)
      0:       return 7;
      1:       return -7;
      2:       return -12;
      3:       return 33;
      4:       return 8;
      5:       return -93;
      6:       return 27;
      7:       return 390;
      8:       return 511;
      9:       return 203;
      10:      return -77;
      11:      return -48;
      12:      return 38;
      13:      return 9;
      14:      return -16;
      15:      return 4;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/if_rail_demux.sv
module if_rail_demux #(
  parameter int SAMP_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     samp_vld,
  input  logic signed [SAMP_W-1:0] samp,
  input  logic                     swap_iq,
  output logic signed [SAMP_W-1:0] rail_i,
  output logic signed [SAMP_W-1:0] rail_q,
  output logic                     pair_vld
);
  localparam logic signed [SAMP_W-1:0] S_MIN = {1'b1, {(SAMP_W-1){1'b0}}};

  function automatic logic signed [SAMP_W-1:0] neg_sat(input logic signed [SAMP_W-1:0] v);
    return (v == S_MIN) ? ~S_MIN : -v;
  endfunction

  logic [1:0]              phase;
  logic                    invert_now;
  logic                    pair_done;
  logic signed [SAMP_W-1:0] signed_samp;
  logic signed [SAMP_W-1:0] hold;

  assign invert_now  = phase[1];
  assign pair_done   = samp_vld & phase[0];
  assign signed_samp = invert_now ? neg_sat(samp) : samp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= 2'd0;
      hold     <= '0;
      rail_i   <= '0;
      rail_q   <= '0;
      pair_vld <= 1'b0;
    end else begin
      pair_vld <= pair_done;
      if (samp_vld) begin
        phase <= phase + 2'd1;
        if (!phase[0]) begin
          hold <= signed_samp;
        end else begin
          rail_i <= swap_iq ? signed_samp : hold;
          rail_q <= swap_iq ? hold : signed_samp;
        end
      end
    end
  end
endmodule

// File: rtl/if_rail_adder_tree.sv
module if_rail_adder_tree #(
  parameter int LEAVES = 16,
  parameter int IN_W   = 20,
  parameter int SUM_W  = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic signed [IN_W-1:0]  leaf [LEAVES],
  output logic signed [SUM_W-1:0] sum,
  output logic                    sum_vld
);
  localparam int LEVELS = $clog2(LEAVES);
  localparam int NODES  = 2 * LEAVES - 1;

  // Heap-ordered nodes: leaves at the top indices, root at index 0.
  logic signed [SUM_W-1:0] node [NODES];
  logic [LEVELS:0]         vpipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) node[i] <= '0;
      vpipe <= '0;
    end else begin
      for (int k = 0; k < LEAVES; k++) node[LEAVES-1+k] <= SUM_W'(leaf[k]);
      for (int i = 0; i < LEAVES - 1; i++) node[i] <= node[2*i+1] + node[2*i+2];
      vpipe <= {vpipe[LEVELS-1:0], in_vld};
    end
  end

  assign sum     = node[0];
  assign sum_vld = vpipe[LEVELS];
endmodule

// File: rtl/if_rail_fir.sv
module if_rail_fir
  import if_rail_pkg::*;
#(
  parameter int SAMP_W     = 10,
  parameter int OUT_W      = 10,
  parameter int TAPS       = 16,
  parameter int NORM_SHIFT = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic signed [SAMP_W-1:0] x,
  output logic signed [OUT_W-1:0]  y,
  output logic                     y_vld
);
  localparam int PROD_W = SAMP_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(TAPS);
  localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(1) << (NORM_SHIFT - 1);
  localparam logic signed [ACC_W:0] HI   = (ACC_W+1)'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W:0] LO   = -HI - (ACC_W+1)'(1);

  function automatic logic signed [PROD_W-1:0] mul_tap(input logic signed [SAMP_W-1:0] a,
                                                       input int k);
    logic signed [COEF_W-1:0] c;
    c = COEF_W'(rrc_even_tap(k));
    return PROD_W'(a) * PROD_W'(c);
  endfunction

  function automatic logic signed [OUT_W-1:0] norm(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W:0] t;
    t = {a[ACC_W-1], a} + HALF;
    t = t >>> NORM_SHIFT;
    if (t > HI) t = HI;
    else if (t < LO) t = LO;
    return t[OUT_W-1:0];
  endfunction

  logic signed [SAMP_W-1:0] line [TAPS];
  logic                     line_vld;
  logic signed [PROD_W-1:0] prod_c [TAPS];
  logic signed [ACC_W-1:0]  acc;
  logic                     acc_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) line[k] <= '0;
      line_vld <= 1'b0;
    end else begin
      line_vld <= in_vld;
      if (in_vld) begin
        line[0] <= x;
        for (int k = 1; k < TAPS; k++) line[k] <= line[k-1];
      end
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign prod_c[k] = mul_tap(line[k], k);
  end

  if_rail_adder_tree #(
    .LEAVES(TAPS),
    .IN_W  (PROD_W),
    .SUM_W (ACC_W)
  ) u_tree (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (line_vld),
    .leaf   (prod_c),
    .sum    (acc),
    .sum_vld(acc_vld)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y     <= '0;
      y_vld <= 1'b0;
    end else begin
      y_vld <= acc_vld;
      if (acc_vld) y <= norm(acc);
    end
  end
endmodule

// File: rtl/if_rail_demod.sv
module if_rail_demod #(
  parameter int SAMP_W     = 10,
  parameter int OUT_W      = 10,
  parameter int TAPS       = 16,
  parameter int NORM_SHIFT = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     samp_vld,
  input  logic signed [SAMP_W-1:0] samp,
  input  logic                     swap_iq,
  output logic signed [OUT_W-1:0]  i_out,
  output logic signed [OUT_W-1:0]  q_out,
  output logic                     out_vld
);
  localparam int LATENCY = 3 + $clog2(TAPS);

  logic signed [SAMP_W-1:0] rail_i;
  logic signed [SAMP_W-1:0] rail_q;
  logic                     pair_vld;
  logic signed [OUT_W-1:0]  rail_y [2];
  logic [1:0]               rail_v;

  if_rail_demux #(.SAMP_W(SAMP_W)) u_demux (
    .clk     (clk),
    .rst_n   (rst_n),
    .samp_vld(samp_vld),
    .samp    (samp),
    .swap_iq (swap_iq),
    .rail_i  (rail_i),
    .rail_q  (rail_q),
    .pair_vld(pair_vld)
  );

  for (genvar r = 0; r < 2; r++) begin : g_rail
    if_rail_fir #(
      .SAMP_W    (SAMP_W),
      .OUT_W     (OUT_W),
      .TAPS      (TAPS),
      .NORM_SHIFT(NORM_SHIFT)
    ) u_fir (
      .clk   (clk),
      .rst_n (rst_n),
      .in_vld(pair_vld),
      .x     ((r == 0) ? rail_i : rail_q),
      .y     (rail_y[r]),
      .y_vld (rail_v[r])
    );
  end

  assign i_out   = rail_y[0];
  assign q_out   = rail_y[1];
  assign out_vld = &rail_v;
endmodule

// File: rtl/if_rail_demod_chk.sv
module if_rail_demod_chk #(
  parameter int OUT_W = 10,
  parameter int LAT   = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pair_vld,
  input logic                    out_vld,
  input logic signed [OUT_W-1:0] i_out,
  input logic signed [OUT_W-1:0] q_out
);
  logic [LAT-1:0] due;

  always_ff @(posedge clk) begin
    if (!rst_n) due <= '0;
    else        due <= {due[LAT-2:0], pair_vld};
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_vld && i_out == '0 && q_out == '0));

  // R7
  out_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == due[LAT-1]);

  // R7
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);

  // R2
  pair_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |=> !pair_vld);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> ($stable(i_out) && $stable(q_out)));
endmodule

bind if_rail_demod if_rail_demod_chk #(.OUT_W(OUT_W), .LAT(LATENCY)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pair_vld(pair_vld),
  .out_vld (out_vld),
  .i_out   (i_out),
  .q_out   (q_out)
);

// File: tb/if_rail_demod_test.sv
`timescale 1ns/1ps
module if_rail_demod_test;
  localparam int SW  = 10;
  localparam int OW  = 10;
  localparam int NS  = 10;
  localparam int LAT = 7;
  localparam int DEPTH = 8192;
  localparam int CF [16] = '{7, -7, -12, 33, 8, -93, 27, 390, 511, 203, -77, -48, 38, 9, -16, 4};

  // Vector table: {pattern, amplitude, length, requirement number}
  // pattern 0: I impulse, 1: Q impulse, 2: raw DC, 3: random,
  //         4: random with swap, 5: sign-matched full load, 6: random with gaps
  localparam int NV = 11;
  localparam int VEC [NV][4] = '{
    '{0,   64, 20, 6},   // R6 half rounds up
    '{0,  -64, 20, 6},   // R6 negative half
    '{0,  300, 20, 5},   // R5 impulse response
    '{1, -200, 20, 2},   // R2 Q rail routing
    '{2,  100, 40, 3},   // R3 inversion on DC
    '{3,    0, 200, 5},  // R5 random
    '{4,    0, 200, 4},  // R4 swap per pair
    '{5,  511,  0, 6},   // R6 clipping both ways
    '{5,  300,  0, 5},   // R5 large unclipped
    '{6,    0, 200, 8},  // R8 gaps
    '{0,    1, 20, 6}    // R6 small values round to zero
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_vld = 1'b0;
  logic swap_iq = 1'b0;
  logic signed [SW-1:0] samp = '0;
  logic signed [OW-1:0] i_out, q_out;
  logic out_vld;

  always #2.5 clk = ~clk;

  if_rail_demod uut (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp(samp),
    .swap_iq(swap_iq), .i_out(i_out), .q_out(q_out), .out_vld(out_vld)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit exp_v [DEPTH];
  int exp_i [DEPTH];
  int exp_q [DEPTH];
  string exp_tag [DEPTH];

  int m_phase, m_hold;
  int hi [16];
  int hq [16];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_name(input int n);
    case (n)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      8: return "R8";
      default: return "R7";
    endcase
  endfunction

  function automatic int negsat(input int v);
    return (v == -512) ? 511 : -v;
  endfunction

  function automatic int norm_ref(input int acc);
    int t, d, q;
    d = 1 << NS;
    t = acc + d / 2;
    if (t >= 0) q = t / d;
    else q = -((-t + d - 1) / d);
    if (q > 511) q = 511;
    if (q < -512) q = -512;
    return q;
  endfunction

  task automatic model_reset();
    m_phase = 0;
    m_hold = 0;
    for (int k = 0; k < 16; k++) begin hi[k] = 0; hq[k] = 0; end
  endtask

  task automatic get_rnd(output int v);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    v = int'($signed(lfsr[9:0]));
  endtask

  task automatic drive(input int s, input bit v, input bit sw, input string tag);
    int r, ai, aq, idx;
    @(negedge clk);
    samp = SW'(s);
    samp_vld = v;
    swap_iq = sw;
    if (v) begin
      r = (m_phase >= 2) ? negsat(s) : s;
      if (m_phase % 2 == 0) m_hold = r;
      else begin
        for (int k = 15; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
        hi[0] = sw ? r : m_hold;
        hq[0] = sw ? m_hold : r;
        ai = 0; aq = 0;
        for (int k = 0; k < 16; k++) begin ai += CF[k] * hi[k]; aq += CF[k] * hq[k]; end
        idx = cyc + 1 + LAT;
        if (idx < DEPTH) begin
          exp_v[idx] = 1'b1;
          exp_i[idx] = norm_ref(ai);
          exp_q[idx] = norm_ref(aq);
          exp_tag[idx] = tag;
        end
      end
      m_phase = (m_phase + 1) % 4;
    end
  endtask

  task automatic pair_rail(input int ri, input int rq, input string tag);
    drive((m_phase >= 2) ? -ri : ri, 1'b1, 1'b0, tag);
    drive((m_phase >= 2) ? -rq : rq, 1'b1, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0, 1'b0, 1'b0, "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    samp_vld = 1'b0;
    for (int k = 1; k <= 24; k++) if (cyc + k < DEPTH) exp_v[cyc+k] = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    chk(out_vld === 1'b0, "R1 out_vld in reset", int'(out_vld), 0);
    chk(i_out === '0, "R1 i_out in reset", int'(i_out), 0);
    chk(q_out === '0, "R1 q_out in reset", int'(q_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(negedge clk) begin
    if (!done && cyc < DEPTH && (exp_v[cyc] || out_vld === 1'b1)) begin
      if (out_vld !== exp_v[cyc])
        chk(1'b0, "R7 out_vld timing", int'(out_vld), int'(exp_v[cyc]));
      else begin
        chk(int'(i_out) == exp_i[cyc], {exp_tag[cyc], " i_out"}, int'(i_out), exp_i[cyc]);
        chk(int'(q_out) == exp_q[cyc], {exp_tag[cyc], " q_out"}, int'(q_out), exp_q[cyc]);
      end
    end
  end

  initial begin
    int v;
    model_reset();
    repeat (3) @(negedge clk);
    chk(out_vld === 1'b0, "R1 out_vld after reset", int'(out_vld), 0);
    chk(i_out === '0, "R1 i_out after reset", int'(i_out), 0);
    chk(q_out === '0, "R1 q_out after reset", int'(q_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    for (int e = 0; e < NV; e++) begin
      case (VEC[e][0])
        0: begin
          pair_rail(VEC[e][1], 0, tag_name(VEC[e][3]));
          for (int j = 0; j < VEC[e][2]; j++) pair_rail(0, 0, tag_name(VEC[e][3]));
        end
        1: begin
          pair_rail(0, VEC[e][1], tag_name(VEC[e][3]));
          for (int j = 0; j < VEC[e][2]; j++) pair_rail(0, 0, tag_name(VEC[e][3]));
        end
        2: for (int j = 0; j < VEC[e][2]; j++) drive(VEC[e][1], 1'b1, 1'b0, tag_name(VEC[e][3]));
        3: for (int j = 0; j < VEC[e][2]; j++) begin
             get_rnd(v);
             drive(v, 1'b1, 1'b0, tag_name(VEC[e][3]));
           end
        4: for (int j = 0; j < VEC[e][2]; j++) begin
             get_rnd(v);
             drive(v, 1'b1, 1'((j >> 1) & 1), tag_name(VEC[e][3]));
           end
        5: begin
          for (int j = 0; j < 16; j++) begin
            int sg;
            sg = (CF[15-j] > 0) ? 1 : -1;
            pair_rail(VEC[e][1] * sg, -VEC[e][1] * sg, tag_name(VEC[e][3]));
          end
          for (int j = 0; j < 16; j++) pair_rail(0, 0, tag_name(VEC[e][3]));
        end
        default: for (int j = 0; j < VEC[e][2]; j++) begin
             get_rnd(v);
             drive(v, (j % 3) != 2, 1'b0, tag_name(VEC[e][3]));
           end
      endcase
      idle(12);
    end

    // R3: most negative raw sample on an inverted slot
    while (m_phase != 2) drive(0, 1'b1, 1'b0, "R3");
    drive(-512, 1'b1, 1'b0, "R3");
    drive(0, 1'b1, 1'b0, "R3");
    for (int j = 0; j < 18; j++) pair_rail(0, 0, "R3");
    idle(12);

    // R1: reset in mid-pair with outputs non-zero, then phase restart
    pair_rail(400, 0, "R1");
    for (int j = 0; j < 4; j++) pair_rail(0, 0, "R1");
    drive(55, 1'b1, 1'b0, "R1");
    do_reset();
    pair_rail(-300, 150, "R1");
    for (int j = 0; j < 18; j++) pair_rail(0, 0, "R1");
    idle(12);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule